// File: doc/BRIEF.md
# Hysteresis Filter for Adaptive Coefficient Updates

This block sits between the sign-sign update logic of an adaptive equalizer and the DAC that sets one loop parameter, such as a feedback tap weight or a target data level. Each clock it takes one raise request and one lower request and adds a signed step to a two's-complement accumulator. The size of the step depends on which way it moves the accumulator. A step that pulls the value back toward zero has magnitude 3. A step that pushes it away from zero has magnitude 1. Because of this asymmetry, a request stream that dithers around the optimum decays back to zero and does not build up. In steady state the coefficient therefore stays still.

When the accumulator enters its upper or lower threshold band, a three-state machine gives a one-cycle increment or decrement pulse. The machine is in ST_TRACK while it accumulates, and goes to ST_FIRE_INC or ST_FIRE_DEC when the next value crosses a threshold. From either fire state it always returns to ST_TRACK on the next clock, and on that clock the accumulator clears. The same pulse moves a saturating coefficient pointer up or down by one. The accumulator width and the pointer width are parameters. A tap instance and a level instance can use different widths, so that the two adaptation loops settle at different rates.

Top module: `hyst_coef_filter`

## Requirements
- R1: During and after reset the accumulator is zero, the pointer equals PTR_RST (mid-scale by default) and both pulse outputs are low.
- R2: In ST_TRACK, a cycle with neither request or with both requests high leaves the accumulator unchanged.
- R3: In ST_TRACK, a raise-only request adds +3 when the accumulator is negative (its MSB, the sign bit of the CNT_W-bit two's-complement value, is 1) and +1 when it is zero or positive.
- R4: In ST_TRACK, a lower-only request adds -1 when the accumulator is negative and -3 when it is zero or positive.
- R5: inc_pulse is high exactly while the machine is in ST_FIRE_INC, which it enters when the accumulator takes a value whose top two bits are 01 (at least 2^(CNT_W-2)). dec_pulse is high exactly in ST_FIRE_DEC, entered on top bits 10 (below -2^(CNT_W-2)). Each pulse lasts one cycle and the two are never high together.
- R6: On the clock that ends a pulse cycle the accumulator returns to zero and the requests of that cycle are ignored.
- R7: On the clock that ends an inc_pulse cycle the pointer rises by one, except at PTR_MAX where it stays.
- R8: On the clock that ends a dec_pulse cycle the pointer falls by one, except at PTR_MIN where it stays.
- R9: The pointer holds its value in every cycle without a pulse.
- R10: The pulse thresholds follow CNT_W. For example, with CNT_W = 6 sixteen raise requests from zero produce an increment pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_req | input | 1 | Raise request from the update logic |
| dn_req | input | 1 | Lower request from the update logic |
| inc_pulse | output | 1 | One-cycle increment pulse (ST_FIRE_INC) |
| dec_pulse | output | 1 | One-cycle decrement pulse (ST_FIRE_DEC) |
| coef_ptr | output | PTR_W | Saturating coefficient pointer for the DAC |

## Verification
The step-size properties assume the requests are steady around each rising edge. They also assume the accumulator is reached only through legal steps from zero, so it can never wrap from the top band into the bottom band. Any mix of requests keeps to that, because every path from zero meets a threshold first. The random stimulus draws up/down mixes from a fixed seed with several biases, including runs where both requests are high. Directed runs drive the accumulator exactly to each threshold, send requests during a pulse cycle, and push the pointer against both of its limits.

// File: rtl/hlpf_pkg.sv
package hlpf_pkg;

    typedef enum logic [1:0] {
        ST_TRACK    = 2'd0,
        ST_FIRE_INC = 2'd1,
        ST_FIRE_DEC = 2'd2
    } hlpf_state_e;

    typedef enum logic [1:0] {
        REQ_HOLD = 2'd0,
        REQ_UP   = 2'd1,
        REQ_DOWN = 2'd2
    } hlpf_req_e;

    typedef enum logic [1:0] {
        THR_NONE = 2'd0,
        THR_HIGH = 2'd1,
        THR_LOW  = 2'd2
    } hlpf_thr_e;

    typedef enum logic [1:0] {
        MV_HOLD  = 2'd0,
        MV_RAISE = 2'd1,
        MV_LOWER = 2'd2,
        MV_CLAMP = 2'd3
    } hlpf_move_e;

    // Conflicting or absent requests both collapse to a hold.
    function automatic hlpf_req_e decode_req(input logic up, input logic dn);
        hlpf_req_e r;
        unique case ({up, dn})
            2'b10:   r = REQ_UP;
            2'b01:   r = REQ_DOWN;
            default: r = REQ_HOLD;
        endcase
        return r;
    endfunction

    // Two top bits of the accumulator select the threshold band.
    function automatic hlpf_thr_e classify_top(input logic [1:0] top);
        hlpf_thr_e t;
        unique case (top)
            2'b01:   t = THR_HIGH;
            2'b10:   t = THR_LOW;
            default: t = THR_NONE;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/hlpf_stepgen.sv
module hlpf_stepgen
    import hlpf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             up_req,
    input  logic             dn_req,
    input  logic             acc_neg,
    output logic [CNT_W-1:0] addend,
    output logic             carry_in
);

    localparam int PAD_W = CNT_W - 2;

    hlpf_req_e req;
    logic      toward_zero;

    // Magnitude is {toward_zero, 1}: 3 toward zero, 1 away.
    // A decrement uses the inverted magnitude plus a carry-in.
    always_comb begin
        req         = decode_req(up_req, dn_req);
        toward_zero = 1'b0;
        addend      = '0;
        carry_in    = 1'b0;
        unique case (req)
            REQ_UP: begin
                toward_zero = acc_neg;
                addend      = {{PAD_W{1'b0}}, toward_zero, 1'b1};
            end
            REQ_DOWN: begin
                toward_zero = ~acc_neg;
                addend      = ~{{PAD_W{1'b0}}, toward_zero, 1'b1};
                carry_in    = 1'b1;
            end
            default: begin
                addend   = '0;
                carry_in = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hlpf_accum.sv
module hlpf_accum
    import hlpf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] addend,
    input  logic             carry_in,
    output logic [CNT_W-1:0] acc_q,
    output logic             inc_pulse,
    output logic             dec_pulse
);

    localparam int MSB = CNT_W - 1;

    logic [CNT_W-1:0] carry;
    logic [CNT_W-1:0] sum;
    logic [CNT_W-1:0] acc_d;
    hlpf_state_e      state_q;
    hlpf_state_e      state_d;

    assign carry[0] = carry_in;

    // Ripple adder: accumulator plus signed step.
    generate
        for (genvar i = 0; i < CNT_W; i++) begin : g_fa
            assign sum[i] = acc_q[i] ^ addend[i] ^ carry[i];
            if (i < CNT_W - 1) begin : g_cy
                assign carry[i+1] = (acc_q[i] & addend[i]) |
                                    (carry[i] & (acc_q[i] ^ addend[i]));
            end
        end
    endgenerate

    // State register (with the accumulator it governs).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TRACK;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    // Next state and next accumulator value.
    always_comb begin
        state_d = ST_TRACK;
        acc_d   = '0;
        unique case (state_q)
            ST_TRACK: begin
                acc_d = sum;
                unique case (classify_top(sum[MSB -: 2]))
                    THR_HIGH: state_d = ST_FIRE_INC;
                    THR_LOW:  state_d = ST_FIRE_DEC;
                    default:  state_d = ST_TRACK;
                endcase
            end
            ST_FIRE_INC, ST_FIRE_DEC: begin
                acc_d   = '0;
                state_d = ST_TRACK;
            end
            default: begin
                acc_d   = '0;
                state_d = ST_TRACK;
            end
        endcase
    end

    // Outputs decoded from the state alone.
    always_comb begin
        inc_pulse = 1'b0;
        dec_pulse = 1'b0;
        unique case (state_q)
            ST_FIRE_INC: inc_pulse = 1'b1;
            ST_FIRE_DEC: dec_pulse = 1'b1;
            default: begin
                inc_pulse = 1'b0;
                dec_pulse = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hlpf_pointer.sv
module hlpf_pointer
    import hlpf_pkg::*;
#(
    parameter int PTR_W   = 6,
    parameter int PTR_MIN = 0,
    parameter int PTR_MAX = 63,
    parameter int PTR_RST = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_pulse,
    input  logic             dec_pulse,
    output logic [PTR_W-1:0] ptr_q
);

    localparam logic [PTR_W-1:0] LIM_HI = PTR_W'(PTR_MAX);
    localparam logic [PTR_W-1:0] LIM_LO = PTR_W'(PTR_MIN);
    localparam logic [PTR_W-1:0] RST_V  = PTR_W'(PTR_RST);
    localparam logic [PTR_W-1:0] ONE    = PTR_W'(1);

    hlpf_move_e       move;
    logic [PTR_W-1:0] ptr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= RST_V;
        else        ptr_q <= ptr_d;
    end

    always_comb begin
        move = MV_HOLD;
        unique case ({inc_pulse, dec_pulse})
            2'b10:   move = (ptr_q >= LIM_HI) ? MV_CLAMP : MV_RAISE;
            2'b01:   move = (ptr_q <= LIM_LO) ? MV_CLAMP : MV_LOWER;
            default: move = MV_HOLD;
        endcase
    end

    always_comb begin
        unique case (move)
            MV_RAISE: ptr_d = ptr_q + ONE;
            MV_LOWER: ptr_d = ptr_q - ONE;
            default:  ptr_d = ptr_q;
        endcase
    end

endmodule

// File: rtl/hyst_coef_filter.sv
module hyst_coef_filter
    import hlpf_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PTR_W   = 6,
    parameter int PTR_MIN = 0,
    parameter int PTR_MAX = (1 << PTR_W) - 1,
    parameter int PTR_RST = 1 << (PTR_W - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_req,
    input  logic             dn_req,
    output logic             inc_pulse,
    output logic             dec_pulse,
    output logic [PTR_W-1:0] coef_ptr
);

    localparam int SIGN_BIT = CNT_W - 1;

    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] step_addend;
    logic             step_cin;

    hlpf_stepgen #(
        .CNT_W (CNT_W)
    ) u_step (
        .up_req   (up_req),
        .dn_req   (dn_req),
        .acc_neg  (acc_q[SIGN_BIT]),
        .addend   (step_addend),
        .carry_in (step_cin)
    );

    hlpf_accum #(
        .CNT_W (CNT_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .addend    (step_addend),
        .carry_in  (step_cin),
        .acc_q     (acc_q),
        .inc_pulse (inc_pulse),
        .dec_pulse (dec_pulse)
    );

    hlpf_pointer #(
        .PTR_W   (PTR_W),
        .PTR_MIN (PTR_MIN),
        .PTR_MAX (PTR_MAX),
        .PTR_RST (PTR_RST)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_pulse (inc_pulse),
        .dec_pulse (dec_pulse),
        .ptr_q     (coef_ptr)
    );

endmodule

// File: rtl/hyst_coef_filter_chk.sv
module hyst_coef_filter_chk #(
    parameter int CNT_W   = 8,
    parameter int PTR_W   = 6,
    parameter int PTR_MIN = 0,
    parameter int PTR_MAX = 63
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_req,
    input logic             dn_req,
    input logic             inc_pulse,
    input logic             dec_pulse,
    input logic [PTR_W-1:0] coef_ptr,
    input logic [CNT_W-1:0] acc
);

    localparam int               MSB = CNT_W - 1;
    localparam logic [PTR_W-1:0] HI  = PTR_W'(PTR_MAX);
    localparam logic [PTR_W-1:0] LO  = PTR_W'(PTR_MIN);

    logic quiet;
    assign quiet = !inc_pulse && !dec_pulse;

    AST_HOLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && (up_req == dn_req)) |=> (acc == $past(acc))); // R2
    AST_UP_TOWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && up_req && !dn_req && acc[MSB]) |=> (acc == $past(acc) + CNT_W'(3))); // R3
    AST_UP_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && up_req && !dn_req && !acc[MSB]) |=> (acc == $past(acc) + CNT_W'(1))); // R3
    AST_DN_TOWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && dn_req && !up_req && !acc[MSB]) |=> (acc == $past(acc) - CNT_W'(3))); // R4
    AST_DN_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && dn_req && !up_req && acc[MSB]) |=> (acc == $past(acc) - CNT_W'(1))); // R4
    AST_HIGH_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[MSB -: 2] == 2'b01) |-> inc_pulse); // R5
    AST_LOW_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[MSB -: 2] == 2'b10) |-> dec_pulse); // R5
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_pulse && dec_pulse)); // R5
    AST_FIRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_pulse || dec_pulse) |=> (acc == '0 && quiet)); // R6
    AST_PTR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_pulse && coef_ptr < HI) |=> (coef_ptr == $past(coef_ptr) + PTR_W'(1))); // R7
    AST_PTR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_pulse && coef_ptr == HI) |=> (coef_ptr == HI)); // R7
    AST_PTR_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_pulse && coef_ptr > LO) |=> (coef_ptr == $past(coef_ptr) - PTR_W'(1))); // R8
    AST_PTR_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_pulse && coef_ptr == LO) |=> (coef_ptr == LO)); // R8
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(coef_ptr)); // R9

endmodule

bind hyst_coef_filter hyst_coef_filter_chk #(
    .CNT_W   (CNT_W),
    .PTR_W   (PTR_W),
    .PTR_MIN (PTR_MIN),
    .PTR_MAX (PTR_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_req    (up_req),
    .dn_req    (dn_req),
    .inc_pulse (inc_pulse),
    .dec_pulse (dec_pulse),
    .coef_ptr  (coef_ptr),
    .acc       (acc_q)
);

// File: tb/sim_hyst_coef_filter.sv
module sim_hyst_coef_filter;

    localparam int W0 = 8;
    localparam int P0 = 6;
    localparam int W1 = 6;
    localparam int P1 = 4;

    logic          clk    = 1'b0;
    logic          rst_n  = 1'b0;
    logic          up_req = 1'b0;
    logic          dn_req = 1'b0;
    logic          inc0, dec0, inc1, dec1;
    logic [P0-1:0] ptr0;
    logic [P1-1:0] ptr1;

    always #4 clk = ~clk;

    hyst_coef_filter #(.CNT_W(W0), .PTR_W(P0)) u0 (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req),
        .inc_pulse(inc0), .dec_pulse(dec0), .coef_ptr(ptr0));

    hyst_coef_filter #(.CNT_W(W1), .PTR_W(P1)) u1 (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req),
        .inc_pulse(inc1), .dec_pulse(dec1), .coef_ptr(ptr1));

    int checks = 0;
    int fails  = 0;
    int m0_cnt, m0_fire, m0_ptr;
    int m1_cnt, m1_fire, m1_ptr;

    function automatic int nxt(int cnt, bit up, bit dn);
        if (up && !dn) return cnt + ((cnt < 0) ? 3 : 1);
        if (dn && !up) return cnt - ((cnt < 0) ? 1 : 3);
        return cnt;
    endfunction

    function automatic int band(int w, int cnt);
        if (cnt >= (1 << (w - 2))) return 1;
        if (cnt < -(1 << (w - 2))) return -1;
        return 0;
    endfunction

    function automatic int move_ptr(int ptr, int fire, int pmax);
        if (fire > 0 && ptr < pmax) return ptr + 1;
        if (fire < 0 && ptr > 0) return ptr - 1;
        return ptr;
    endfunction

    task automatic chk_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_edge(bit up, bit dn);
        if (m0_fire != 0) begin
            m0_ptr = move_ptr(m0_ptr, m0_fire, (1 << P0) - 1);
            m0_cnt = 0; m0_fire = 0;
        end else begin
            m0_cnt = nxt(m0_cnt, up, dn); m0_fire = band(W0, m0_cnt);
        end
        if (m1_fire != 0) begin
            m1_ptr = move_ptr(m1_ptr, m1_fire, (1 << P1) - 1);
            m1_cnt = 0; m1_fire = 0;
        end else begin
            m1_cnt = nxt(m1_cnt, up, dn); m1_fire = band(W1, m1_cnt);
        end
    endtask

    task automatic compare();
        chk_eq("R5 u0 inc_pulse", int'(inc0), int'(m0_fire == 1));
        chk_eq("R5 u0 dec_pulse", int'(dec0), int'(m0_fire == -1));
        chk_eq("R9 u0 pointer", int'(ptr0), m0_ptr);
        chk_eq("R10 u1 inc_pulse", int'(inc1), int'(m1_fire == 1));
        chk_eq("R10 u1 dec_pulse", int'(dec1), int'(m1_fire == -1));
        chk_eq("R9 u1 pointer", int'(ptr1), m1_ptr);
    endtask

    task automatic tick(bit up, bit dn);
        @(negedge clk);
        up_req = up;
        dn_req = dn;
        @(posedge clk);
        model_edge(up, dn);
        #2;
        compare();
    endtask

    task automatic run(int n, bit up, bit dn);
        for (int i = 0; i < n; i++) tick(up, dn);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; up_req = 1'b0; dn_req = 1'b0;
        repeat (2) @(negedge clk);
        m0_cnt = 0; m0_fire = 0; m0_ptr = 1 << (P0 - 1);
        m1_cnt = 0; m1_fire = 0; m1_ptr = 1 << (P1 - 1);
        chk_eq("R1 u0 pointer in reset", int'(ptr0), 32);
        chk_eq("R1 u1 pointer in reset", int'(ptr1), 8);
        chk_eq("R1 pulses low in reset", int'(inc0 | dec0 | inc1 | dec1), 0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..R10 run did not end actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        do_reset();
        tick(0, 0);
        chk_eq("R1 u0 pointer after reset", int'(ptr0), 32);

        // R10: smaller accumulator fires after 16 raises
        run(15, 1, 0);
        chk_eq("R10 u1 no pulse after 15", int'(inc1), 0);
        tick(1, 0);
        chk_eq("R10 u1 pulse at 16", int'(inc1), 1);
        chk_eq("R10 u0 quiet at 16", int'(inc0), 0);

        // R3: 64 raises from zero reach the high band
        do_reset();
        run(63, 1, 0);
        chk_eq("R3 no pulse after 63 raises", int'(inc0), 0);
        tick(1, 0);
        chk_eq("R3 pulse after 64 raises", int'(inc0), 1);
        tick(0, 0);
        chk_eq("R7 pointer up by one", int'(ptr0), 33);

        // R4: -3 from zero, then -1 steps, band at -65
        run(62, 0, 1);
        chk_eq("R4 no pulse at -64", int'(dec0), 0);
        tick(0, 1);
        chk_eq("R4 pulse at -65", int'(dec0), 1);
        tick(0, 0);
        chk_eq("R8 pointer down by one", int'(ptr0), 32);

        // R3: +3 while negative: -6 back to 0 in two raises
        run(4, 0, 1);
        run(2, 1, 0);
        run(63, 1, 0);
        chk_eq("R3 toward-zero steps no early pulse", int'(inc0), 0);
        tick(1, 0);
        chk_eq("R3 toward-zero steps pulse", int'(inc0), 1);
        tick(0, 0);

        // R4: -3 while positive: 10 -> 7 -> 4 -> 5 -> 6
        run(10, 1, 0);
        run(2, 0, 1);
        run(2, 1, 0);
        run(57, 1, 0);
        chk_eq("R4 toward-zero steps no early pulse", int'(inc0), 0);
        tick(1, 0);
        chk_eq("R4 toward-zero steps pulse", int'(inc0), 1);
        tick(0, 0);

        // R2: both or neither request leave the accumulator alone
        run(30, 1, 0);
        run(20, 1, 1);
        run(10, 0, 0);
        run(33, 1, 0);
        chk_eq("R2 hold cycles add nothing", int'(inc0), 0);
        tick(1, 0);
        chk_eq("R2 pulse on 64th effective raise", int'(inc0), 1);
        tick(0, 0);

        // R6: request during the pulse cycle is dropped, counting restarts
        run(64, 1, 0);
        chk_eq("R6 pulse before ignored request", int'(inc0), 1);
        tick(1, 0);
        run(63, 1, 0);
        chk_eq("R6 restart from zero no pulse", int'(inc0), 0);
        tick(1, 0);
        chk_eq("R6 restart from zero pulse", int'(inc0), 1);
        tick(0, 0);

        // R7: saturate at the top
        for (int k = 0; k < 40; k++) begin
            run(64, 1, 0);
            tick(0, 0);
        end
        chk_eq("R7 pointer at maximum", int'(ptr0), 63);
        run(64, 1, 0);
        tick(0, 0);
        chk_eq("R7 pointer stays at maximum", int'(ptr0), 63);

        // R8: saturate at the bottom
        for (int k = 0; k < 70; k++) begin
            run(63, 0, 1);
            tick(0, 0);
        end
        chk_eq("R8 pointer at minimum", int'(ptr0), 0);
        run(63, 0, 1);
        tick(0, 0);
        chk_eq("R8 pointer stays at minimum", int'(ptr0), 0);

        // Random mixes with several biases
        do_reset();
        void'($urandom(32'h5EED_1234));
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 1000; i++) begin
                int r;
                bit u, d;
                r = int'($urandom % 16);
                case (ph)
                    0: begin u = (r < 9);  d = (r >= 9) && (r < 14); end
                    1: begin u = (r < 4);  d = (r >= 4) && (r < 13); end
                    2: begin u = (r < 8);  d = (r >= 8); end
                    default: begin u = r[0]; d = r[1]; end
                endcase
                tick(u, d);
            end
        end

        finish_run();
    end

endmodule